// File: doc/BRIEF.md
# Card Slot Status and Interrupt Latch

This block is a small register window for a removable memory-card slot. Two status signals come in from the slot. The write-protect switch level is followed continuously. A card-insertion event is caught in a sticky bit that holds after the detect line drops. The insertion bit drives an interrupt line to the system interrupt controller. Software acknowledges the interrupt by writing a one to the insertion bit position.

The window also presents two constant words, an identification value and a decode-configuration value, plus a reserved word that reads zero. All registers sit at word addresses on a simple single-cycle bus. A read returns its data on a registered output in the cycle after the strobe. Reset is synchronous and active high.

Top module: `slot_irq_regs`

## Requirements
- R1: While `rst` is high, the sticky insertion bit and the captured write-protect bit clear. `card_irq` and `bus_rdata` read zero on the edge that sees reset.
- R2: A read of word 0 returns 0x41034003, a read of word 1 returns 0 and a read of word 3 returns 0x00000011.
- R3: Bit 0 of word 2 shows the level of `wprot_in` as sampled on the previous clock edge, for both rising and falling levels.
- R4: Bit 3 of word 2 is set on any clock edge where `cdet_in` is high, and it stays set after `cdet_in` returns low.
- R5: A write to word 2 clears bit 3 only when bit 3 of `bus_wdata` is one. A write with bit 3 zero leaves bit 3 unchanged.
- R6: Written data never changes bit 0 of word 2.
- R7: `card_irq` is a registered copy of bit 3 of word 2. It rises on the edge that sets the bit and falls on the edge that clears it.
- R8: When `cdet_in` is high on the same edge as a clearing write to word 2, bit 3 stays set and `card_irq` stays high.
- R9: Writes to words 0, 1 and 3 have no effect. Their read values and the interrupt are unchanged afterwards.
- R10: Reads of word addresses 4 and above return zero. In word 2, every bit other than bits 0 and 3 reads zero.
- R11: `bus_rdata` updates only on an edge where `bus_rd` is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, data appears the next cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wprot_in | input | 1 | Write-protect switch level from the slot |
| cdet_in | input | 1 | Card-detect pulse or level from the slot |
| card_irq | output | 1 | Interrupt request, high while the insertion bit is set |

## Verification
Several properties are checked on every clock edge:
- The set path of the insertion bit, its hold, its clearing by a write-one and the priority of detect over clear.
- The constant words, the zero reads of unmapped words and the holding of read data between strobes.

Other behaviour can only be shown by the bench scenarios:
- The one-cycle delay of the write-protect bit.
- That written data leaves bit 0 untouched.
- That stray writes to the constant words change nothing.

These are shown by reading the registers back through the bus after each stimulus.

// File: rtl/slot_regs_pkg.sv
package slot_regs_pkg;

  // constant words presented by the window
  localparam logic [31:0] ID_VALUE     = 32'h4103_4003;
  localparam logic [31:0] DECODE_VALUE = 32'h0000_0011;

  // word addresses
  localparam int unsigned WORD_ID    = 0;
  localparam int unsigned WORD_RSVD  = 1;
  localparam int unsigned WORD_SLOT  = 2;
  localparam int unsigned WORD_DEC   = 3;
  localparam int unsigned WORD_COUNT = 4;

  // bit positions inside the slot status word
  localparam int unsigned BIT_WPROT  = 0;
  localparam int unsigned BIT_INSERT = 3;

  typedef struct packed {
    logic id;
    logic rsvd;
    logic slot;
    logic dec;
  } word_hit_t;

endpackage

// File: rtl/slot_reg_decode.sv
module slot_reg_decode
  import slot_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output word_hit_t         rd_hit,
  output logic              slot_wr
);

  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(WORD_ID);
  localparam logic [ADDR_W-1:0] A_RSVD = ADDR_W'(WORD_RSVD);
  localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(WORD_SLOT);
  localparam logic [ADDR_W-1:0] A_DEC  = ADDR_W'(WORD_DEC);

  always_comb begin
    rd_hit      = '0;
    rd_hit.id   = rd && (addr == A_ID);
    rd_hit.rsvd = rd && (addr == A_RSVD);
    rd_hit.slot = rd && (addr == A_SLOT);
    rd_hit.dec  = rd && (addr == A_DEC);
  end

  // only the slot status word accepts writes; the others drop them
  assign slot_wr = wr && (addr == A_SLOT);

endmodule

// File: rtl/slot_status_latch.sv
module slot_status_latch
  import slot_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wprot_in,
  input  logic              cdet_in,
  input  logic              slot_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wprot_q,
  output logic              insert_q
);

  localparam logic [DATA_W-1:0] INSERT_MASK = DATA_W'(1) << BIT_INSERT;

  logic ack;

  assign ack = slot_wr && ((wdata & INSERT_MASK) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wprot_q  <= 1'b0;
      insert_q <= 1'b0;
    end else begin
      wprot_q <= wprot_in;
      // detect wins over acknowledge on the same edge
      if (cdet_in)
        insert_q <= 1'b1;
      else if (ack)
        insert_q <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
  import slot_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  word_hit_t         hit,
  input  logic              wprot_q,
  input  logic              insert_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] slot_word;

  always_comb begin
    slot_word             = '0;
    slot_word[BIT_WPROT]  = wprot_q;
    slot_word[BIT_INSERT] = insert_q;
  end

  always_comb begin
    rdata_d = '0;
    if (hit.id)   rdata_d = DATA_W'(ID_VALUE);
    if (hit.rsvd) rdata_d = '0;
    if (hit.slot) rdata_d = slot_word;
    if (hit.dec)  rdata_d = DATA_W'(DECODE_VALUE);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= rdata_d;
  end

endmodule

// File: rtl/slot_irq_regs.sv
module slot_irq_regs
  import slot_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wprot_in,
  input  logic              cdet_in,
  output logic              card_irq
);

  word_hit_t rd_hit;
  logic      slot_wr;
  logic      wprot_q;
  logic      insert_q;

  slot_reg_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .rd_hit  (rd_hit),
    .slot_wr (slot_wr)
  );

  slot_status_latch #(.DATA_W(DATA_W)) lat_i (
    .clk      (clk),
    .rst      (rst),
    .wprot_in (wprot_in),
    .cdet_in  (cdet_in),
    .slot_wr  (slot_wr),
    .wdata    (bus_wdata),
    .wprot_q  (wprot_q),
    .insert_q (insert_q)
  );

  slot_read_mux #(.DATA_W(DATA_W)) mux_i (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .hit      (rd_hit),
    .wprot_q  (wprot_q),
    .insert_q (insert_q),
    .rdata    (bus_rdata)
  );

  // the interrupt is the insertion flop itself, so it is registered
  assign card_irq = insert_q;

endmodule

// File: rtl/slot_irq_regs_chk.sv
module slot_irq_regs_chk
  import slot_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wprot_in,
  input logic              cdet_in,
  input logic              card_irq
);

  logic past_ok;
  logic clocked;
  logic ack_now;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  always_ff @(posedge clk) clocked <= 1'b1;

  assign ack_now = bus_wr && (bus_addr == ADDR_W'(WORD_SLOT)) && bus_wdata[BIT_INSERT];

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    (clocked === 1'b1) && $past(rst) |-> (card_irq == 1'b0 && bus_rdata == '0));

  // R4 and R8: a high detect always leaves the interrupt set
  a_r4_detect_sets: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cdet_in) |-> card_irq);

  // R4
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(card_irq) && !$past(ack_now) |-> card_irq);

  // R5 and R7
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(ack_now) && !$past(cdet_in) |-> !card_irq);

  // R7: no set without a detect
  a_r7_no_spurious_rise: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(cdet_in) |-> !$rose(card_irq));

  // R2
  a_r2_id_word: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(bus_rd && bus_addr == ADDR_W'(WORD_ID)) |-> bus_rdata == DATA_W'(ID_VALUE));

  // R2
  a_r2_decode_word: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(bus_rd && bus_addr == ADDR_W'(WORD_DEC)) |-> bus_rdata == DATA_W'(DECODE_VALUE));

  // R10
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(bus_rd && bus_addr >= ADDR_W'(WORD_COUNT)) |-> bus_rdata == '0);

  // R10: the slot word carries at most its two status bits
  a_r10_slot_bits: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(bus_rd && bus_addr == ADDR_W'(WORD_SLOT)) |-> $countones(bus_rdata) <= 2);

  // R11
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind slot_irq_regs slot_irq_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/slot_irq_regs_tb_top.sv
module slot_irq_regs_tb_top;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [31:0] ID_W  = 32'h4103_4003;
  localparam logic [31:0] DEC_W = 32'h0000_0011;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        wp;
    logic        cd;
    logic        chk;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;

  // one entry per cycle; outputs compared after the edge that consumed it
  localparam vec_t [0:NV-1] VECS = '{
    '{1'b0, 1'b1, 4'd0, 32'h0, 1'b0, 1'b0, 1'b1, ID_W,          1'b0, 8'd2 },  // R2 id word
    '{1'b0, 1'b1, 4'd1, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 8'd2 },  // R2 reserved word
    '{1'b0, 1'b1, 4'd3, 32'h0, 1'b0, 1'b0, 1'b1, DEC_W,         1'b0, 8'd2 },  // R2 decode word
    '{1'b0, 1'b1, 4'd9, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 8'd10},  // R10 unmapped
    '{1'b0, 1'b1, 4'd2, 32'h0, 1'b1, 1'b0, 1'b1, 32'h0,         1'b0, 8'd3 },  // R3 not yet seen
    '{1'b0, 1'b1, 4'd2, 32'h0, 1'b1, 1'b0, 1'b1, 32'h1,         1'b0, 8'd3 },  // R3 rise
    '{1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 1'b1, 1'b1, 32'h1,         1'b1, 8'd7 },  // R7 rise, R11 hold
    '{1'b0, 1'b1, 4'd2, 32'h0, 1'b1, 1'b0, 1'b1, 32'h9,         1'b1, 8'd4 },  // R4 sticky
    '{1'b1, 1'b0, 4'd2, 32'h1, 1'b1, 1'b0, 1'b1, 32'h9,         1'b1, 8'd5 },  // R5 bit3 zero keeps
    '{1'b0, 1'b1, 4'd2, 32'h0, 1'b1, 1'b0, 1'b1, 32'h9,         1'b1, 8'd6 },  // R6 bit0 unchanged
    '{1'b1, 1'b0, 4'd2, 32'hFFFF_FFF7, 1'b0, 1'b0, 1'b1, 32'h9, 1'b1, 8'd5 },  // R5 all but bit3
    '{1'b0, 1'b1, 4'd2, 32'h0, 1'b0, 1'b0, 1'b1, 32'h8,         1'b1, 8'd3 },  // R3 fall
    '{1'b1, 1'b0, 4'd2, 32'h8, 1'b0, 1'b0, 1'b1, 32'h8,         1'b0, 8'd7 },  // R7 fall, R5 clear
    '{1'b0, 1'b1, 4'd2, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 8'd5 },  // R5 cleared
    '{1'b1, 1'b0, 4'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 8'd9 },  // R9
    '{1'b1, 1'b0, 4'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 8'd9 },  // R9
    '{1'b1, 1'b0, 4'd0, 32'h0000_0008, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 8'd9 },  // R9
    '{1'b0, 1'b1, 4'd3, 32'h0, 1'b0, 1'b0, 1'b1, DEC_W,         1'b0, 8'd9 },  // R9
    '{1'b0, 1'b1, 4'd1, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 8'd9 },  // R9
    '{1'b0, 1'b1, 4'd0, 32'h0, 1'b0, 1'b0, 1'b1, ID_W,          1'b0, 8'd9 },  // R9
    '{1'b0, 1'b0, 4'd7, 32'h0, 1'b0, 1'b0, 1'b1, ID_W,          1'b0, 8'd11},  // R11 hold
    '{1'b0, 1'b1, 4'd15, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 8'd10}   // R10 top word
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              wprot_in = 1'b0;
  logic              cdet_in = 1'b0;
  logic              card_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  slot_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wprot_in  (wprot_in),
    .cdet_in   (cdet_in),
    .card_irq  (card_irq)
  );

  task automatic check_val(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input logic wr, input logic rd, input logic [3:0] addr,
                      input logic [31:0] wdata, input logic wp, input logic cd);
    bus_wr    = wr;
    bus_rd    = rd;
    bus_addr  = addr;
    bus_wdata = wdata;
    wprot_in  = wp;
    cdet_in   = cd;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: outputs after reset edges, with slot inputs active during reset
    @(negedge clk);
    wprot_in = 1'b1;
    cdet_in  = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R1", "irq in reset", {31'b0, card_irq}, 32'h0);
    check_val("R1", "rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'd2, 32'h0, 1'b0, 1'b0);
    check_val("R1", "slot word after reset", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wdata, VECS[i].wp, VECS[i].cd);
      if (VECS[i].chk) begin
        check_val($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rdata", i),
                  bus_rdata, VECS[i].exp_rd);
        check_val($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d irq", i),
                  {31'b0, card_irq}, {31'b0, VECS[i].exp_irq});
      end
    end

    // R8: detect and acknowledge on the same edge, detect wins
    step(1'b1, 1'b0, 4'd2, 32'h8, 1'b0, 1'b1);
    check_val("R8", "irq after collision", {31'b0, card_irq}, 32'h1);
    step(1'b0, 1'b1, 4'd2, 32'h0, 1'b0, 1'b0);
    check_val("R8", "slot word after collision", bus_rdata, 32'h8);
    step(1'b1, 1'b0, 4'd2, 32'h8, 1'b0, 1'b0);
    check_val("R5", "irq after plain ack", {31'b0, card_irq}, 32'h0);

    // R4: a long detect level followed by a fall keeps the bit
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 1'b0);
    check_val("R4", "irq held after detect fall", {31'b0, card_irq}, 32'h1);

    // R1: reset mid-run clears a set interrupt and read data
    step(1'b0, 1'b1, 4'd0, 32'h0, 1'b1, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 1'b0);
    check_val("R1", "irq after reset", {31'b0, card_irq}, 32'h0);
    check_val("R1", "rdata after reset", bus_rdata, 32'h0);
    rst = 1'b0;
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'd2, 32'h0, 1'b0, 1'b0);
    check_val("R1", "slot word after mid reset", bus_rdata, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule